// File: doc/BRIEF.md
# Indirect Dual-RAM Host Access Bridge

This block gives a host processor indirect access to two external synchronous memories through a small register file. The host loads a 128-bit data value into four 32-bit data registers and a 128-bit bitwise write mask into four mask registers. It then writes a command word that holds a direction bit, a target-select bit and an address. That one write starts exactly one memory cycle. A status register reports whether a cycle is running and whether the last triggered cycle has finished.

Target-select 0 addresses a 128-bit-wide table RAM with an 8-bit address. Writes to it are masked bit by bit, so they run as a read-modify-write: the entry is read, merged with the data registers under the mask, and written back. Target-select 1 addresses an 8-bit-wide buffer RAM with a 14-bit address. For the buffer, only the low byte of data register 0 takes part. Both RAMs are expected to return read data one cycle after the enable.

The host port is a plain register port. A write takes effect on the clock edge where `host_we` is high. Read data is a combinational decode of `host_addr`, and reading has no side effects.

Top module: `dual_ram_bridge`

## Requirements
- R1: After reset, every register reads 0, including command, data, mask and status, and both RAM enables are low.
- R2: Only a host write at offset 0x00 starts a memory cycle. Host reads of any offset cause no RAM enable and leave the status unchanged.
- R3: Command word layout:
  - bit 31 is write-not-read (1 = write).
  - bit 30 selects the target (0 = table, 1 = buffer).
  - The table address is bits [7:0] and the buffer address is bits [13:0]. Other bits do not affect the address.
- R4: A table read loads the addressed 128-bit entry into the data registers. Offset 0x04 receives bits [31:0], 0x08 bits [63:32], 0x0C bits [95:64] and 0x10 bits [127:96].
- R5: A table write reads the entry and then writes back the same address with `(old & ~mask) | (data & mask)`. Mask words sit at offsets 0x14..0x20 and follow the same word order as the data registers.
- R6: A buffer write stores bits [7:0] of data register 0 at the 14-bit address. Data registers 1..3 and all mask registers have no effect on it.
- R7: A buffer read loads the byte into bits [7:0] of data register 0. Bits [31:8] of that register and data registers 1..3 keep their values.
- R8: The status register at 0x24 has bit 0 = done and bit 1 = busy. Done is cleared by an accepted trigger and set when the cycle ends. It then stays set until the next accepted trigger; writes to other registers do not clear it.
- R9: A write to offset 0x00 while busy is ignored. The command register keeps its value and no extra RAM access occurs.
- R10: Busy is 1 directly after the trigger edge. Done is 1 and the read data is in the data registers two clock edges after the trigger edge.
- R11: The two RAM enables are never high in the same cycle. The RAM that is not targeted sees no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational decode) |
| tbl_en | output | 1 | Table RAM enable |
| tbl_we | output | 1 | Table RAM write enable |
| tbl_addr | output | 8 | Table RAM address |
| tbl_wdata | output | 128 | Table RAM write data (merged) |
| tbl_rdata | input | 128 | Table RAM read data, one cycle after enable |
| buf_en | output | 1 | Buffer RAM enable |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_addr | output | 14 | Buffer RAM address |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, one cycle after enable |

## Verification
The busy bit is due on the first clock edge after the trigger. Done, captured read data and the write-back of a table merge are all due on the second edge after it. A buffer write reaches the RAM on the first edge. The bench drives each host write at a falling edge and returns at the following falling edge, just after the trigger edge. It reads busy there and reads done and data two falling edges later, so every sample falls half a period after the edge that produced it. RAM access counts and the captured buffer write address are recorded by the bench's own memory models at the rising edge and compared only after the cycle has completed.

// File: rtl/dr_bridge_pkg.sv
package dr_bridge_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_CAP  = 2'd2
   } dr_state_e;

   localparam int STAT_DONE_BIT = 0;
   localparam int STAT_BUSY_BIT = 1;

endpackage

// File: rtl/dr_merge.sv
module dr_merge #(
   parameter int NWORD  = 4,
   parameter int WORD_W = 32
) (
   input  logic [NWORD*WORD_W-1:0] old_q,
   input  logic [NWORD*WORD_W-1:0] new_d,
   input  logic [NWORD*WORD_W-1:0] mask,
   output logic [NWORD*WORD_W-1:0] merged
);

   for (genvar w = 0; w < NWORD; w++) begin : g_word
      localparam int LO = w * WORD_W;
      assign merged[LO +: WORD_W] = (old_q[LO +: WORD_W] & ~mask[LO +: WORD_W])
                                  | (new_d[LO +: WORD_W] &  mask[LO +: WORD_W]);
   end

endmodule

// File: rtl/dr_seq.sv
module dr_seq
   import dr_bridge_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic sel,
   input  logic wnr,
   output logic busy,
   output logic done,
   output logic tbl_en,
   output logic tbl_we,
   output logic buf_en,
   output logic buf_we,
   output logic cap_tbl,
   output logic cap_buf
);

   dr_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_ACC;
               done    <= 1'b0;
            end
            ST_ACC:  state_q <= ST_CAP;
            ST_CAP: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy    = (state_q != ST_IDLE);
      tbl_en  = 1'b0;
      tbl_we  = 1'b0;
      buf_en  = 1'b0;
      buf_we  = 1'b0;
      cap_tbl = 1'b0;
      cap_buf = 1'b0;
      if (state_q == ST_ACC) begin
         tbl_en = !sel;
         buf_en = sel;
         buf_we = sel && wnr;
      end else if (state_q == ST_CAP) begin
         tbl_en  = !sel && wnr;
         tbl_we  = !sel && wnr;
         cap_tbl = !sel && !wnr;
         cap_buf = sel && !wnr;
      end
   end

   assert_done_on_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CAP) |=> done);
   assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);
   assert_busy_excl_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
   assert_one_ram_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(tbl_en && buf_en));

endmodule

// File: rtl/dual_ram_bridge.sv
module dual_ram_bridge
   import dr_bridge_pkg::*;
#(
   parameter int HADDR_W = 8,
   parameter int WORD_W  = 32,
   parameter int NWORD   = 4,
   parameter int TBL_AW  = 8,
   parameter int BUF_AW  = 14,
   parameter int BUF_DW  = 8,
   parameter int WNR_BIT = 31,
   parameter int SEL_BIT = 30
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      host_we,
   input  logic [HADDR_W-1:0]        host_addr,
   input  logic [WORD_W-1:0]         host_wdata,
   output logic [WORD_W-1:0]         host_rdata,
   output logic                      tbl_en,
   output logic                      tbl_we,
   output logic [TBL_AW-1:0]         tbl_addr,
   output logic [NWORD*WORD_W-1:0]   tbl_wdata,
   input  logic [NWORD*WORD_W-1:0]   tbl_rdata,
   output logic                      buf_en,
   output logic                      buf_we,
   output logic [BUF_AW-1:0]         buf_addr,
   output logic [BUF_DW-1:0]         buf_wdata,
   input  logic [BUF_DW-1:0]         buf_rdata
);

   localparam int STEP     = WORD_W / 8;
   localparam int DAT_BASE = STEP;
   localparam int MSK_BASE = STEP * (1 + NWORD);
   localparam int STAT_BASE = STEP * (1 + 2 * NWORD);
   localparam logic [HADDR_W-1:0] CTL_OFF  = '0;
   localparam logic [HADDR_W-1:0] STAT_OFF = HADDR_W'(STAT_BASE);

   initial begin
      chk_sel_ne_wnr: assert (SEL_BIT != WNR_BIT) else $error("select and direction bits overlap");
      chk_addr_fit:   assert (TBL_AW <= SEL_BIT && BUF_AW <= SEL_BIT && BUF_AW <= WNR_BIT)
         else $error("address field overlaps control bits");
      chk_byte_fit:   assert (BUF_DW <= WORD_W) else $error("buffer width exceeds data word");
      chk_map_fit:    assert (STAT_BASE < (1 << HADDR_W)) else $error("register map exceeds host address");
   end

   logic                           busy, done, cap_tbl, cap_buf, trig;
   logic [WORD_W-1:0]              ctl_q;
   logic [NWORD-1:0][WORD_W-1:0]   dat_q;
   logic [NWORD-1:0][WORD_W-1:0]   msk_q;

   assign trig = host_we && (host_addr == CTL_OFF) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (trig) ctl_q <= host_wdata;
   end

   for (genvar w = 0; w < NWORD; w++) begin : g_regs
      localparam logic [HADDR_W-1:0] DAT_OFF = HADDR_W'(DAT_BASE + STEP * w);
      localparam logic [HADDR_W-1:0] MSK_OFF = HADDR_W'(MSK_BASE + STEP * w);

      if (w == 0) begin : g_byte_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dat_q[w] <= '0;
            else if (cap_tbl)
               dat_q[w] <= tbl_rdata[w*WORD_W +: WORD_W];
            else if (cap_buf)
               dat_q[w][BUF_DW-1:0] <= buf_rdata;
            else if (host_we && host_addr == DAT_OFF)
               dat_q[w] <= host_wdata;
         end
      end else begin : g_wide_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               dat_q[w] <= '0;
            else if (cap_tbl)
               dat_q[w] <= tbl_rdata[w*WORD_W +: WORD_W];
            else if (host_we && host_addr == DAT_OFF)
               dat_q[w] <= host_wdata;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            msk_q[w] <= '0;
         else if (host_we && host_addr == MSK_OFF)
            msk_q[w] <= host_wdata;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == CTL_OFF) host_rdata = ctl_q;
      for (int w = 0; w < NWORD; w++) begin
         if (host_addr == HADDR_W'(DAT_BASE + STEP * w)) host_rdata = dat_q[w];
         if (host_addr == HADDR_W'(MSK_BASE + STEP * w)) host_rdata = msk_q[w];
      end
      if (host_addr == STAT_OFF) begin
         host_rdata[STAT_DONE_BIT] = done;
         host_rdata[STAT_BUSY_BIT] = busy;
      end
   end

   dr_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (trig),
      .sel     (ctl_q[SEL_BIT]),
      .wnr     (ctl_q[WNR_BIT]),
      .busy    (busy),
      .done    (done),
      .tbl_en  (tbl_en),
      .tbl_we  (tbl_we),
      .buf_en  (buf_en),
      .buf_we  (buf_we),
      .cap_tbl (cap_tbl),
      .cap_buf (cap_buf)
   );

   dr_merge #(.NWORD(NWORD), .WORD_W(WORD_W)) u_merge (
      .old_q  (tbl_rdata),
      .new_d  (dat_q),
      .mask   (msk_q),
      .merged (tbl_wdata)
   );

   assign tbl_addr  = ctl_q[TBL_AW-1:0];
   assign buf_addr  = ctl_q[BUF_AW-1:0];
   assign buf_wdata = dat_q[0][BUF_DW-1:0];

   assert_busy_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_we && host_addr == CTL_OFF) |=> $stable(ctl_q));
   assert_rmw_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_en && tbl_we) |-> ($past(tbl_en && !tbl_we) && $past(tbl_addr) == tbl_addr));
   assert_no_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(host_we && host_addr == CTL_OFF)) |=> !busy);
   assert_buf_quiet_table_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ctl_q[SEL_BIT]) |-> !buf_en);

endmodule

// File: tb/dual_ram_bridge_tb.sv
`timescale 1ns/1ps
module dual_ram_bridge_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_we = 1'b0;
   logic [7:0]   host_addr = '0;
   logic [31:0]  host_wdata = '0;
   logic [31:0]  host_rdata;
   logic         tbl_en, tbl_we, buf_en, buf_we;
   logic [7:0]   tbl_addr;
   logic [127:0] tbl_wdata;
   logic [127:0] tbl_rdata = '0;
   logic [13:0]  buf_addr;
   logic [7:0]   buf_wdata;
   logic [7:0]   buf_rdata = '0;

   always #2 clk = ~clk;

   dual_ram_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tbl_en(tbl_en), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
      .buf_en(buf_en), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
   );

   logic [127:0] tbl_mem [256];
   logic [7:0]   buf_mem [64];
   logic [127:0] ref_tbl [256];
   logic [7:0]   ref_buf [64];
   int           tbl_acc_cnt = 0, buf_acc_cnt = 0, both_en_cnt = 0;
   logic [13:0]  last_buf_waddr = '0;
   int           checks = 0, errors = 0;

   function automatic logic [127:0] seed_entry(input int i);
      logic [127:0] v;
      for (int k = 0; k < 4; k++)
         v[k*32 +: 32] = (32'(i) * 32'h9E3779B9) ^ (32'h11111111 * 32'(k + 1));
      return v;
   endfunction

   always @(posedge clk) begin
      if (tbl_en) begin
         tbl_acc_cnt <= tbl_acc_cnt + 1;
         if (tbl_we) tbl_mem[tbl_addr] <= tbl_wdata;
         else        tbl_rdata <= tbl_mem[tbl_addr];
      end
      if (buf_en) begin
         buf_acc_cnt <= buf_acc_cnt + 1;
         if (buf_we) begin
            buf_mem[buf_addr[5:0]] <= buf_wdata;
            last_buf_waddr <= buf_addr;
         end else
            buf_rdata <= buf_mem[buf_addr[5:0]];
      end
   end

   always @(negedge clk) if (tbl_en && buf_en) both_en_cnt <= both_en_cnt + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hr(input logic [7:0] a, output logic [31:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait2;
      @(negedge clk);
      @(negedge clk);
   endtask

   // ctl, data, mask, word index
   localparam int NV = 12;
   localparam logic [97:0] VECS [NV] = '{
      {32'h80000087, 32'h7B070000, 32'hFFFF0000, 2'd2},
      {32'h00000087, 32'h00000000, 32'h00000000, 2'd0},
      {32'h80000010, 32'hDEADBEEF, 32'h0F0F00FF, 2'd0},
      {32'h80000010, 32'h12345678, 32'hFFFFFFFF, 2'd3},
      {32'h00002210, 32'h00000000, 32'h00000000, 2'd1},
      {32'hC0002A05, 32'h000000C3, 32'hFFFFFFFF, 2'd0},
      {32'h40002A05, 32'hABCDEF00, 32'h00000000, 2'd0},
      {32'hC0003FFF, 32'h0000005A, 32'h12345678, 2'd0},
      {32'h40003FFF, 32'h77777777, 32'h00000000, 2'd0},
      {32'h800000FF, 32'hFFFFFFFF, 32'h80000001, 2'd1},
      {32'h000000FF, 32'h00000000, 32'h00000000, 2'd0},
      {32'h80000000, 32'h00000000, 32'hFFFFFFFF, 2'd2}
   };

   initial begin
      logic [31:0] r, ctl, d, m;
      logic [31:0] pre [4];
      logic [1:0]  w;
      int          tcnt, bcnt;

      for (int i = 0; i < 256; i++) begin
         tbl_mem[i] = seed_entry(i);
         ref_tbl[i] = seed_entry(i);
      end
      for (int i = 0; i < 64; i++) begin
         buf_mem[i] = 8'(i) ^ 8'h3C;
         ref_buf[i] = 8'(i) ^ 8'h3C;
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of all registers and RAM enables
      for (int a = 0; a <= 36; a += 4) begin
         hr(8'(a), r);
         chk("R1 reg zero after reset", r, 32'h0);
      end
      chk("R1 enables low", {30'h0, tbl_en, buf_en}, 32'h0);

      // Vector table: R3 R4 R5 R6 R7 R8 R10
      for (int v = 0; v < NV; v++) begin
         ctl = VECS[v][97:66];
         d   = VECS[v][65:34];
         m   = VECS[v][33:2];
         w   = VECS[v][1:0];
         for (int k = 0; k < 4; k++) begin
            pre[k] = (2'(k) == w) ? d : ~d;
            hw(8'(4 + 4*k), pre[k]);
            hw(8'(20 + 4*k), (2'(k) == w) ? m : 32'h0);
         end
         tcnt = tbl_acc_cnt;
         bcnt = buf_acc_cnt;
         hw(8'h00, ctl);
         hr(8'h24, r);
         chk("R10 busy right after trigger", r, 32'h2);
         wait2;
         hr(8'h24, r);
         chk("R8 R10 done two edges after trigger", r, 32'h1);
         if (!ctl[30]) begin
            chk("R11 buffer untouched by table cycle", 32'(buf_acc_cnt - bcnt), 32'h0);
            if (ctl[31]) begin
               for (int k = 0; k < 4; k++) begin
                  logic [31:0] mk;
                  mk = (2'(k) == w) ? m : 32'h0;
                  ref_tbl[ctl[7:0]][k*32 +: 32] =
                     (ref_tbl[ctl[7:0]][k*32 +: 32] & ~mk) | (pre[k] & mk);
               end
               chk("R5 rmw is read plus write", 32'(tbl_acc_cnt - tcnt), 32'h2);
               hw(8'h00, {24'h0, ctl[7:0]});
               wait2;
            end
            for (int k = 0; k < 4; k++) begin
               hr(8'(4 + 4*k), r);
               chk(ctl[31] ? "R5 masked merge readback" : "R4 R3 table read word",
                   r, ref_tbl[ctl[7:0]][k*32 +: 32]);
            end
         end else begin
            chk("R11 table untouched by buffer cycle", 32'(tbl_acc_cnt - tcnt), 32'h0);
            if (ctl[31]) begin
               ref_buf[ctl[5:0]] = pre[0][7:0];
               chk("R6 R3 buffer write address", {18'h0, last_buf_waddr}, {18'h0, ctl[13:0]});
               hw(8'h00, {18'h1000 >> 2, ctl[13:0]} | 32'h40000000);
               wait2;
               hr(8'h04, r);
               chk("R6 buffer byte readback", {24'h0, r[7:0]}, {24'h0, ref_buf[ctl[5:0]]});
            end else begin
               hr(8'h04, r);
               chk("R7 buffer read low byte and upper bits kept",
                   r, {pre[0][31:8], ref_buf[ctl[5:0]]});
               hr(8'h08, r);
               chk("R7 data reg 1 kept", r, pre[1]);
               hr(8'h10, r);
               chk("R7 data reg 3 kept", r, pre[3]);
            end
         end
      end

      // R9: trigger while busy is ignored
      tcnt = tbl_acc_cnt;
      hw(8'h00, 32'h00000010);
      hw(8'h00, 32'h80000033);
      @(negedge clk);
      hr(8'h00, r);
      chk("R9 command kept during busy", r, 32'h00000010);
      chk("R9 no extra access", 32'(tbl_acc_cnt - tcnt), 32'h1);
      hr(8'h04, r);
      chk("R9 first command completed", r, ref_tbl[8'h10][31:0]);

      // R8: done is sticky
      repeat (5) @(negedge clk);
      hr(8'h24, r);
      chk("R8 done sticky while idle", r, 32'h1);
      hw(8'h04, 32'hCAFEF00D);
      hr(8'h24, r);
      chk("R8 data write keeps done", r, 32'h1);

      // R2: reads have no side effect
      tcnt = tbl_acc_cnt;
      bcnt = buf_acc_cnt;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         hr(8'h00, r);
      end
      chk("R2 command read starts nothing", 32'(tbl_acc_cnt + buf_acc_cnt - tcnt - bcnt), 32'h0);
      hr(8'h24, r);
      chk("R2 status unchanged by reads", r, 32'h1);

      hw(8'h00, 32'h00000001);
      hr(8'h24, r);
      chk("R8 trigger clears done", r, 32'h2);
      wait2;

      chk("R11 never both enables", 32'(both_en_cnt), 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule